// File: doc/BRIEF.md
# Banked GPIO Controller with Set/Clear Register Writes

This block controls 32 general-purpose pins from a plain 32-bit register bus. The pins form two banks of sixteen, and each bank is reached through its own address window. Every per-pin configuration register in a window is written in a split format. A 1 in the lower half turns the feature on for that pin, and a 1 in the upper half turns it off. Software can therefore change single pins without a read-modify-write, and two agents that touch different pins never race.

For each pin the controller keeps an output level, an output drive enable, an output polarity flip, an input enable and an input polarity flip. Inputs are resynchronised, then checked for rising and falling edges, and each detected edge sets a sticky flag. Four routing words, one for every group of eight pins, send each pin's pending event to one of eight event pairs. The event then appears as either a normal interrupt line or a power-management line.

The bus has no handshake. A write takes effect on the clock edge where `bus_wr` is high. Read data is valid in the same cycle as `bus_rd` and is combinational from the stored state, so the bus never stalls.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: Pins 0 to 15 are controlled through the window at address 0x00. Pins 16 to 31 are controlled through the window at 0x80, where window bit n refers to pin 16+n.
- R2: In a feature register write, bit n (n = 0..15) sets the feature for window pin n and bit n+16 clears it. A zero bit leaves the stored value alone. When both bits are 1, the clear takes priority.
- R3: A read of a feature register returns the per-pin state in bits [15:0] and zero in bits [31:16]. `bus_rdata` is zero whenever `bus_rd` is low.
- R4: The window offsets are as follows. 0x00 is output level, 0x04 output enable, 0x0C output invert, 0x20 input enable, 0x24 input invert, 0x38 event enable, 0x40 rising-edge enable, 0x44 falling-edge enable, 0x48 rising-edge flag and 0x4C falling-edge flag.
- R5: `pin_oe` equals the output enable bits. `pin_out` equals (output level XOR output invert) AND output enable, and it changes only after a write to 0x00, 0x04 or 0x0C of its bank.
- R6: Offset 0x30 returns the window's pin levels after the synchroniser, which has SYNC_STAGES flops (default 2). Writes to 0x30 change nothing.
- R7: A rising (falling) flag is set when the synchronised input, XORed with its input-invert bit, goes from 0 to 1 (1 to 0) while the pin's input enable and the matching edge enable are both 1. A pin with input enable 0 never sets a flag.
- R8: Edge flags stay set until a write puts a 1 in their clear half. An edge detected in the same cycle as the clear leaves the flag set.
- R9: Four routing words at 0xE0, 0xE4, 0xE8 and 0xEC cover pins 0-7, 8-15, 16-23 and 24-31 in that order. They are written and read as whole 32-bit values, and pin p uses the 4-bit field starting at bit (p mod 8)*4.
- R10: A pin is pending when its event enable is 1 and either of its edge flags is 1. A pending pin drives `irq_pair[f[2:0]]` if bit 3 of its field f is 0, or `pme_pair[f[2:0]]` if that bit is 1. Pair lines with no pending pin are 0.
- R11: Reads of any other address return zero, and writes to any other address change nothing, including 0x08, 0x50 and addresses with bits [1:0] non-zero.
- R12: After reset every register, flag, routing word and output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| pin_in | input | 32 | Pin levels from the pads, asynchronous |
| pin_out | output | 32 | Output levels to the pads |
| pin_oe | output | 32 | Output drive enables to the pads |
| irq_pair | output | 8 | Interrupt-type event pair lines |
| pme_pair | output | 8 | Power-management-type event pair lines |

## Verification
The bench builds the block with its default SYNC_STAGES of 2, which sets how long it waits between moving `pin_in` and reading a level or a flag. At that value, and with both banks built, the bench can reach the second window and the upper routing words as well as the first window. Set/clear collisions, inverted inputs that turn a physical rise into a logical fall, and the switch of one pending pin from the interrupt set to the power-management set of lines are all driven.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;
  localparam int BANK_PINS  = 16;
  localparam int NUM_BANKS  = 2;
  localparam int NUM_PINS   = BANK_PINS * NUM_BANKS;
  localparam int GROUP_PINS = 8;
  localparam int NUM_GROUPS = NUM_PINS / GROUP_PINS;
  localparam int NUM_PAIRS  = 8;
  localparam int FIELD_W    = 4;

  localparam logic [6:0] OFF_OLVL = 7'h00;
  localparam logic [6:0] OFF_OEN  = 7'h04;
  localparam logic [6:0] OFF_OINV = 7'h0C;
  localparam logic [6:0] OFF_IEN  = 7'h20;
  localparam logic [6:0] OFF_IINV = 7'h24;
  localparam logic [6:0] OFF_LVL  = 7'h30;
  localparam logic [6:0] OFF_EVEN = 7'h38;
  localparam logic [6:0] OFF_RISE = 7'h40;
  localparam logic [6:0] OFF_FALL = 7'h44;
  localparam logic [6:0] OFF_RFLG = 7'h48;
  localparam logic [6:0] OFF_FFLG = 7'h4C;

  function automatic logic [BANK_PINS-1:0] setclr(input logic [BANK_PINS-1:0] cur,
                                                  input logic [2*BANK_PINS-1:0] wd);
    return (cur | wd[BANK_PINS-1:0]) & ~wd[2*BANK_PINS-1:BANK_PINS];
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_setclr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [6:0]           off,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [BANK_PINS-1:0] pin_in,
  output logic [BANK_PINS-1:0] pin_out,
  output logic [BANK_PINS-1:0] pin_oe,
  output logic [BANK_PINS-1:0] pend
);
  logic [BANK_PINS-1:0] olvl_q, oen_q, oinv_q, ien_q, iinv_q;
  logic [BANK_PINS-1:0] even_q, rise_q, fall_q, rflg_q, fflg_q;
  logic [BANK_PINS-1:0] lvl_s, adj, adj_prev_q, rise_hit, fall_hit;
  logic [BANK_PINS-1:0] rdata_lo;

  gpio_pin_sync #(.W(BANK_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (lvl_s)
  );

  assign adj      = lvl_s ^ iinv_q;
  assign rise_hit = adj & ~adj_prev_q & ien_q & rise_q;
  assign fall_hit = ~adj & adj_prev_q & ien_q & fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      olvl_q <= '0; oen_q <= '0; oinv_q <= '0; ien_q <= '0; iinv_q <= '0;
      even_q <= '0; rise_q <= '0; fall_q <= '0; rflg_q <= '0; fflg_q <= '0;
      adj_prev_q <= '0;
    end else begin
      adj_prev_q <= adj;
      if (wr_en && off == OFF_OLVL) olvl_q <= setclr(olvl_q, wdata);
      if (wr_en && off == OFF_OEN)  oen_q  <= setclr(oen_q, wdata);
      if (wr_en && off == OFF_OINV) oinv_q <= setclr(oinv_q, wdata);
      if (wr_en && off == OFF_IEN)  ien_q  <= setclr(ien_q, wdata);
      if (wr_en && off == OFF_IINV) iinv_q <= setclr(iinv_q, wdata);
      if (wr_en && off == OFF_EVEN) even_q <= setclr(even_q, wdata);
      if (wr_en && off == OFF_RISE) rise_q <= setclr(rise_q, wdata);
      if (wr_en && off == OFF_FALL) fall_q <= setclr(fall_q, wdata);
      if (wr_en && off == OFF_RFLG) rflg_q <= setclr(rflg_q, wdata) | rise_hit;
      else                          rflg_q <= rflg_q | rise_hit;
      if (wr_en && off == OFF_FFLG) fflg_q <= setclr(fflg_q, wdata) | fall_hit;
      else                          fflg_q <= fflg_q | fall_hit;
    end
  end

  always_comb begin
    case (off)
      OFF_OLVL: rdata_lo = olvl_q;
      OFF_OEN:  rdata_lo = oen_q;
      OFF_OINV: rdata_lo = oinv_q;
      OFF_IEN:  rdata_lo = ien_q;
      OFF_IINV: rdata_lo = iinv_q;
      OFF_LVL:  rdata_lo = lvl_s;
      OFF_EVEN: rdata_lo = even_q;
      OFF_RISE: rdata_lo = rise_q;
      OFF_FALL: rdata_lo = fall_q;
      OFF_RFLG: rdata_lo = rflg_q;
      OFF_FFLG: rdata_lo = fflg_q;
      default:  rdata_lo = '0;
    endcase
  end

  assign rdata   = {{(32-BANK_PINS){1'b0}}, rdata_lo};
  assign pin_oe  = oen_q;
  assign pin_out = (olvl_q ^ oinv_q) & oen_q;
  assign pend    = even_q & (rflg_q | fflg_q);

  // R2
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == OFF_OLVL) |=> ((olvl_q & $past(wdata[31:16])) == '0));

  // R8
  rflg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && off == OFF_RFLG) |=> (($past(rflg_q) & ~rflg_q) == '0));

  // R8
  fflg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && off == OFF_FFLG) |=> (($past(fflg_q) & ~fflg_q) == '0));

  // R5
  pad_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (off == OFF_OLVL || off == OFF_OEN || off == OFF_OINV))
      |=> $stable(pin_out));

  // R7
  ien_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && off == OFF_RFLG) && ien_q == '0) |=> $stable(rflg_q));
endmodule

// File: rtl/gpio_evt_route.sv
module gpio_evt_route
  import gpio_setclr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            idx,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic [NUM_PINS-1:0]   pend,
  output logic [NUM_PAIRS-1:0]  irq_pair,
  output logic [NUM_PAIRS-1:0]  pme_pair
);
  localparam int PAIR_W = $clog2(NUM_PAIRS);

  logic [31:0] route_q [NUM_GROUPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NUM_GROUPS; g++) route_q[g] <= '0;
    end else if (wr_en) begin
      route_q[idx] <= wdata;
    end
  end

  assign rdata = route_q[idx];

  always_comb begin
    logic [FIELD_W-1:0] fld;
    irq_pair = '0;
    pme_pair = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      fld = route_q[p / GROUP_PINS][(p % GROUP_PINS)*FIELD_W +: FIELD_W];
      if (pend[p]) begin
        if (fld[FIELD_W-1]) pme_pair[fld[PAIR_W-1:0]] = 1'b1;
        else                irq_pair[fld[PAIR_W-1:0]] = 1'b1;
      end
    end
  end

  // R10
  no_pend_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (irq_pair == '0 && pme_pair == '0));

  // R9
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(route_q[0]) && $stable(route_q[NUM_GROUPS-1]));
endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
  import gpio_setclr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pin_in,
  output logic [31:0] pin_out,
  output logic [31:0] pin_oe,
  output logic [7:0]  irq_pair,
  output logic [7:0]  pme_pair
);
  logic                aligned, route_hit;
  logic [31:0]         bank_rdata [NUM_BANKS];
  logic [31:0]         route_rdata;
  logic [NUM_PINS-1:0] pend;

  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign route_hit = aligned && (bus_addr[7:4] == 4'hE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = bus_wr && aligned && !route_hit && (bus_addr[7] == b[0]);
    gpio_bank #(.SYNC_STAGES(SYNC_STAGES)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bank_wr),
      .off    (bus_addr[6:0]),
      .wdata  (bus_wdata),
      .rdata  (bank_rdata[b]),
      .pin_in (pin_in [b*BANK_PINS +: BANK_PINS]),
      .pin_out(pin_out[b*BANK_PINS +: BANK_PINS]),
      .pin_oe (pin_oe [b*BANK_PINS +: BANK_PINS]),
      .pend   (pend   [b*BANK_PINS +: BANK_PINS])
    );
  end

  gpio_evt_route u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr && route_hit),
    .idx     (bus_addr[3:2]),
    .wdata   (bus_wdata),
    .rdata   (route_rdata),
    .pend    (pend),
    .irq_pair(irq_pair),
    .pme_pair(pme_pair)
  );

  always_comb begin
    if (!bus_rd || !aligned) bus_rdata = '0;
    else if (route_hit)      bus_rdata = route_rdata;
    else                     bus_rdata = bank_rdata[bus_addr[7]];
  end

  // R3
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));

  // R3
  upper_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !route_hit) |-> (bus_rdata[31:16] == '0));
endmodule

// File: tb/gpio_setclr_ctrl_bench.sv
module gpio_setclr_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic [7:0]  irq_pair, pme_pair;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_setclr_ctrl u_gpio_setclr_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_pair(irq_pair), .pme_pair(pme_pair)
  );

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] rx;
    logic [31:0] px;
  } vec_t;

  // R1 R2 R4 R5 R9: write, read back, expected pad output
  localparam vec_t VECS [10] = '{
    '{8'h00, 32'h0000_00FF, 8'h00, 32'h0000_00FF, 32'h0000_0000},
    '{8'h04, 32'h0000_000F, 8'h04, 32'h0000_000F, 32'h0000_000F},
    '{8'h00, 32'h0003_0000, 8'h00, 32'h0000_00FC, 32'h0000_000C},
    '{8'h0C, 32'h0000_0001, 8'h0C, 32'h0000_0001, 32'h0000_000D},
    '{8'h80, 32'h0001_0001, 8'h80, 32'h0000_0000, 32'h0000_000D},
    '{8'h80, 32'h0000_8001, 8'h80, 32'h0000_8001, 32'h0000_000D},
    '{8'h84, 32'h0000_8000, 8'h84, 32'h0000_8000, 32'h8000_000D},
    '{8'h8C, 32'h0000_8000, 8'h8C, 32'h0000_8000, 32'h0000_000D},
    '{8'hE4, 32'h1234_5678, 8'hE4, 32'h1234_5678, 32'h0000_000D},
    '{8'h00, 32'h0000_0000, 8'h00, 32'h0000_00FC, 32'h0000_000D}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(1);
    // R12 reset state
    check("R12 pin_out", pin_out, 32'h0);
    check("R12 pin_oe", pin_oe, 32'h0);
    rd(8'hE0, v); check("R12 route", v, 32'h0);
    rd(8'h48, v); check("R12 flag", v, 32'h0);

    for (int i = 0; i < 10; i++) begin
      wr(VECS[i].wa, VECS[i].wd);
      rd(VECS[i].ra, v);
      check("R2 table read", v, VECS[i].rx);
      check("R5 table pad", pin_out, VECS[i].px);
    end
    check("R5 pin_oe", pin_oe, 32'h8000_000F);

    // R3 read with bus_rd low
    @(negedge clk); bus_addr = 8'h00; #1;
    check("R3 idle rdata", bus_rdata, 32'h0);

    // R11 unmapped offsets
    wr(8'h50, 32'h0000_FFFF); rd(8'h50, v); check("R11 unmapped read", v, 32'h0);
    wr(8'h08, 32'h0000_FFFF); rd(8'h08, v); check("R11 0x08 read", v, 32'h0);
    wr(8'h01, 32'h00FF_0000); rd(8'h00, v); check("R11 misaligned write", v, 32'h0000_00FC);
    check("R11 pads unchanged", pin_out, 32'h0000_000D);

    // R6 level readback and write ignored
    @(negedge clk); pin_in = 32'h0005_0003;
    wait_clks(3);
    rd(8'h30, v); check("R6 bank0 level", v, 32'h0000_0003);
    rd(8'hB0, v); check("R1 R6 bank1 level", v, 32'h0000_0005);
    wr(8'h30, 32'hFFFF_0000); rd(8'h30, v); check("R6 write ignored", v, 32'h0000_0003);

    // R7 disabled input: pin 5 edge enabled but input off
    wr(8'h40, 32'h0000_0028);
    @(negedge clk); pin_in[5] = 1'b1;
    wait_clks(4);
    rd(8'h48, v); check("R7 input disabled", v, 32'h0);

    // R7 rising edge on pin 3
    wr(8'h20, 32'h0000_0008);
    @(negedge clk); pin_in[3] = 1'b1;
    wait_clks(4);
    rd(8'h48, v); check("R7 rising flag", v, 32'h0000_0008);
    @(negedge clk); pin_in[3] = 1'b0;
    wait_clks(4);
    rd(8'h48, v); check("R8 flag sticky", v, 32'h0000_0008);

    // R10 routing to pairs
    check("R10 no event enable", {pme_pair, irq_pair}, 16'h0);
    wr(8'h38, 32'h0000_0008);
    wr(8'hE0, 32'h0000_5000);
    check("R10 irq pair 5", {pme_pair, irq_pair}, 16'h0020);
    wr(8'hE0, 32'h0000_D000);
    check("R10 pme pair 5", {pme_pair, irq_pair}, 16'h2000);
    wr(8'h48, 32'h0008_0000);
    rd(8'h48, v); check("R8 flag cleared", v, 32'h0);
    check("R10 lines drop", {pme_pair, irq_pair}, 16'h0);

    // R7 R1 inverted falling edge on pin 20 (bank1 bit 4)
    @(negedge clk); pin_in[20] = 1'b0;
    wait_clks(4);
    wr(8'hA0, 32'h0000_0010);
    wr(8'hC4, 32'h0000_0010);
    wr(8'hA4, 32'h0000_0010);
    wait_clks(2);
    rd(8'hCC, v); check("R7 no fall yet", v, 32'h0);
    @(negedge clk); pin_in[20] = 1'b1;
    wait_clks(4);
    rd(8'hCC, v); check("R7 inverted fall flag", v, 32'h0000_0010);
    wr(8'hB8, 32'h0000_0010);
    wr(8'hE8, 32'h0007_0000);
    check("R10 bank1 irq pair 7", {pme_pair, irq_pair}, 16'h0080);

    // R12 reset clears again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R12 pads after reset", pin_out, 32'h0);
    check("R12 pairs after reset", {pme_pair, irq_pair}, 16'h0);
    rd(8'hE4, v); check("R12 route after reset", v, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule